// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a 16-bit timer counter with one status and control byte on a simple register bus. The byte holds an overflow flag, an interrupt enable for that flag, a mode bit, a two-bit clock source code and a three-bit prescale code. The counter either counts up to a modulo value and wraps to zero, or counts up to the modulo value and then back down to zero (center-aligned mode). A modulo value of zero lets the counter run over the full 16-bit range.

Counting is paced by the bus clock, an alternate clock or an external clock. Both non-bus sources are synchronized into the bus clock domain and turned into one-cycle count pulses. A power-of-two prescaler follows the source selection. Software clears the overflow flag in two steps: it reads the byte while the flag is set and then writes 0 to the flag bit. An overflow that arrives between those two steps cancels the clear. The interrupt request is the flag gated by its enable.

Top module: `modtmr_top`

## Requirements
- R1: After reset the control byte reads 0x00, the counter is 0x0000 and the interrupt request is low.
- R2: A write updates bits 6..0 of the control byte (6 interrupt enable, 5 center mode, 4..3 clock source, 2..0 prescale) at the next clock edge, and a read returns them.
- R3: With clock source code 00 the counter holds its value and the prescaler returns to zero.
- R4: In up mode the counter advances by one per count step and, at a step taken while it equals the modulo value, becomes 0x0000 and sets the flag (bit 7) in that same edge.
- R5: With modulo value 0x0000 the counter runs through 0xFFFF and the flag sets on the wrap to 0x0000 after 65536 steps.
- R6: Prescale code P gives one count step per 2^P source pulses, counted from the moment counting was last enabled.
- R7: In center mode (bit 5 = 1) the counter counts up to the modulo value, then down to 0x0000, then up again; the flag sets at the step from the modulo value to the value one below, and not at zero.
- R8: The flag clears only when a write with bit 7 = 0 follows a read made while the flag was 1; a write of 0 without such a read, or a write of 1, leaves it unchanged.
- R9: An overflow that occurs after the qualifying read and before the clearing write cancels the clear, and the flag stays 1.
- R10: The interrupt request is high exactly while both the flag and the interrupt enable are 1.
- R11: Source code 01 gives a pulse every bus cycle, code 10 one pulse per rising edge of the alternate clock and code 11 one per rising edge of the external clock; edges of the unselected source have no effect.
- R12: Changing the mode or the source keeps the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the control byte |
| bus_rd | input | 1 | Read strobe for the control byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control byte |
| alt_clk | input | 1 | Alternate count source, slower than half the bus clock |
| ext_clk | input | 1 | External count source, slower than half the bus clock |
| modulo | input | 16 | Modulo value, 0 means full range |
| count_out | output | 16 | Counter value |
| irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle the checker confirms that a disabled counter holds still, that the flag never drops without a bus write and is never raised by writing 1, that an up-mode overflow lands on zero while a center-mode overflow lands one below the previous value, that written control fields appear, and that the interrupt follows flag and enable. The exact count sequences under each modulo and prescale setting, the prescaler restart on disable, the synchronized source pulses, the value retained across mode changes and the cancelling of a clear by an overflow in mid-sequence are shown only by the bench's sweeps and scenarios.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
   typedef enum logic [1:0] {
      SRC_OFF = 2'b00,
      SRC_BUS = 2'b01,
      SRC_ALT = 2'b10,
      SRC_EXT = 2'b11
   } src_sel_e;

   localparam int BIT_FLAG   = 7;
   localparam int BIT_IE     = 6;
   localparam int BIT_CENTER = 5;
   localparam int BIT_SRC_HI = 4;
   localparam int BIT_SRC_LO = 3;
endpackage

// File: rtl/modtmr_clksel.sv
module modtmr_clksel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       alt_clk,
   input  logic       ext_clk,
   input  logic [1:0] sel,
   output logic       tick
);
   import modtmr_pkg::*;

   logic [1:0] raw_src;
   logic [1:0] edge_q;

   assign raw_src = {ext_clk, alt_clk};

   for (genvar g = 0; g < 2; g++) begin : g_src
      logic [SYNC_STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-1:0], raw_src[g]};
      end
      assign edge_q[g] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
   end

   always_comb begin
      case (src_sel_e'(sel))
         SRC_BUS: tick = 1'b1;
         SRC_ALT: tick = edge_q[0];
         SRC_EXT: tick = edge_q[1];
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/modtmr_prescale.sv
module modtmr_prescale #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            tick,
   input  logic [PS_W-1:0] ps,
   output logic            step
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] acc;
   logic [DIV_W-1:0] mask;

   assign mask = (DIV_W'(1) << ps) - DIV_W'(1);
   assign step = tick & ((acc & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (!enable) acc <= '0;
      else if (tick)    acc <= acc + DIV_W'(1);
   end
endmodule

// File: rtl/modtmr_counter.sv
module modtmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             center,
   input  logic [CNT_W-1:0] modulo,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] nxt;
   logic             down, nxt_down;

   assign top = (modulo == '0) ? '1 : modulo;

   always_comb begin
      nxt      = count;
      nxt_down = down;
      ovf      = 1'b0;
      if (!center) begin
         nxt_down = 1'b0;
         if (step) begin
            if (count >= top) begin
               nxt = '0;
               ovf = 1'b1;
            end else begin
               nxt = count + CNT_W'(1);
            end
         end
      end else if (step) begin
         if (!down) begin
            if (count >= top) begin
               nxt      = count - CNT_W'(1);
               nxt_down = 1'b1;
               ovf      = 1'b1;
            end else begin
               nxt = count + CNT_W'(1);
            end
         end else if (count == '0) begin
            nxt      = CNT_W'(1);
            nxt_down = 1'b0;
         end else begin
            nxt = count - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         down  <= 1'b0;
      end else begin
         count <= nxt;
         down  <= nxt_down;
      end
   end
endmodule

// File: rtl/modtmr_ctrl.sv
module modtmr_ctrl #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic            bus_rd,
   input  logic [7:0]      wdata,
   input  logic            ovf,
   output logic [7:0]      rdata,
   output logic            flag,
   output logic            ie,
   output logic            center,
   output logic [1:0]      sel,
   output logic [PS_W-1:0] ps
);
   import modtmr_pkg::*;

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         armed  <= 1'b0;
         ie     <= 1'b0;
         center <= 1'b0;
         sel    <= 2'b00;
         ps     <= '0;
      end else begin
         if (bus_wr) begin
            ie     <= wdata[BIT_IE];
            center <= wdata[BIT_CENTER];
            sel    <= wdata[BIT_SRC_HI:BIT_SRC_LO];
            ps     <= wdata[PS_W-1:0];
         end
         if (ovf) begin
            flag  <= 1'b1;
            armed <= 1'b0;
         end else if (bus_wr) begin
            if (armed && !wdata[BIT_FLAG]) flag <= 1'b0;
            armed <= 1'b0;
         end else if (bus_rd && flag) begin
            armed <= 1'b1;
         end
      end
   end

   assign rdata = {flag, ie, center, sel, 3'(ps)};
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top #(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic             alt_clk,
   input  logic             ext_clk,
   input  logic [CNT_W-1:0] modulo,
   output logic [CNT_W-1:0] count_out,
   output logic             irq
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("modtmr_top: CNT_W must be at least 2");
   end
   if (PS_W < 1 || PS_W > 3) begin : g_bad_ps
      $error("modtmr_top: PS_W must lie in 1..3");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modtmr_top: SYNC_STAGES must be at least 2");
   end

   logic            flag, ie, center;
   logic [1:0]      sel;
   logic [PS_W-1:0] ps;
   logic            tick, step, ovf_evt;

   modtmr_ctrl #(.PS_W(PS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .wdata(bus_wdata), .ovf(ovf_evt), .rdata(bus_rdata),
      .flag(flag), .ie(ie), .center(center), .sel(sel), .ps(ps)
   );

   modtmr_clksel #(.SYNC_STAGES(SYNC_STAGES)) u_clksel (
      .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .ext_clk(ext_clk),
      .sel(sel), .tick(tick)
   );

   modtmr_prescale #(.PS_W(PS_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .enable(sel != 2'b00), .tick(tick),
      .ps(ps), .step(step)
   );

   modtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .center(center),
      .modulo(modulo), .count(count_out), .ovf(ovf_evt)
   );

   assign irq = flag & ie;
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [7:0]       bus_wdata,
   input logic [7:0]       bus_rdata,
   input logic [CNT_W-1:0] count_out,
   input logic             irq,
   input logic             ovf_evt
);
   // R3
   disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[4:3] == 2'b00) |=> $stable(count_out));

   // R8
   flag_no_silent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[7] && !bus_wr) |=> bus_rdata[7]);

   // R8
   flag_write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wdata[7] && !bus_rdata[7] && !ovf_evt) |=> !bus_rdata[7]);

   // R4
   up_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !bus_rdata[5]) |=> (count_out == '0));

   // R7
   center_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && bus_rdata[5]) |=> (count_out == $past(count_out) - CNT_W'(1)));

   // R2
   field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (bus_rdata[6:3] == $past(bus_wdata[6:3])));

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (bus_rdata[7] & bus_rdata[6]));
endmodule

bind modtmr_top modtmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .count_out(count_out), .irq(irq), .ovf_evt(ovf_evt)
);

// File: tb/sim_modtmr_top.sv
module sim_modtmr_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        alt_clk = 1'b0, ext_clk = 1'b0;
   logic [15:0] modulo = 16'h0000;
   logic [15:0] count_out;
   logic        irq;

   int total = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modtmr_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_clk(alt_clk),
      .ext_clk(ext_clk), .modulo(modulo), .count_out(count_out), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic wr(logic [7:0] d);
      bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd();
      bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_alt(int n);
      for (int i = 0; i < n; i++) begin
         alt_clk = 1'b1; idle(4); alt_clk = 1'b0; idle(4);
      end
   endtask

   task automatic pulse_ext(int n);
      for (int i = 0; i < n; i++) begin
         ext_clk = 1'b1; idle(4); ext_clk = 1'b0; idle(4);
      end
   endtask

   task automatic sweep_up(int m, int p);
      int steps, ec, ef, bad;
      string tag;
      do_reset();
      modulo = 16'(m);
      wr(8'h08 | 8'(p));
      bad = 0;
      for (int j = 1; j <= (m + 1) * (1 << p) * 2 + 3 && bad == 0; j++) begin
         @(negedge clk);
         steps = j >> p;
         ec = steps % (m + 1);
         ef = (steps >= m + 1) ? 1 : 0;
         if (count_out !== 16'(ec) || bus_rdata[7] !== ef[0]) begin
            bad = 1;
            tag = $sformatf("R4 R6 up m=%0d ps=%0d j=%0d {flag,count}", m, p, j);
            chk(tag, {15'd0, bus_rdata[7], count_out}, {15'd0, ef[0], 16'(ec)});
         end
      end
      if (bad == 0) chk("R4 R6 up sweep", 32'd0, 32'd0);
   endtask

   task automatic sweep_center(int m, int p);
      int steps, v, ec, ef, bad;
      string tag;
      do_reset();
      modulo = 16'(m);
      wr(8'h28 | 8'(p));
      bad = 0;
      for (int j = 1; j <= 4 * m * (1 << p) + 2 && bad == 0; j++) begin
         @(negedge clk);
         steps = j >> p;
         v = steps % (2 * m);
         ec = (v <= m) ? v : 2 * m - v;
         ef = (steps >= m + 1) ? 1 : 0;
         if (count_out !== 16'(ec) || bus_rdata[7] !== ef[0]) begin
            bad = 1;
            tag = $sformatf("R7 center m=%0d ps=%0d j=%0d {flag,count}", m, p, j);
            chk(tag, {15'd0, bus_rdata[7], count_out}, {15'd0, ef[0], 16'(ec)});
         end
      end
      if (bad == 0) chk("R7 center sweep", 32'd0, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      // R1 reset state
      idle(2);
      rst_n = 1'b1;
      idle(1);
      chk("R1 control byte", 32'(bus_rdata), 32'h00);
      chk("R1 counter", 32'(count_out), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 fields written and read back
      wr(8'h75);
      chk("R2 readback 0x75", 32'(bus_rdata), 32'h75);
      wr(8'h00);
      chk("R2 readback 0x00", 32'(bus_rdata), 32'h00);

      // R4 R6 up mode sweep
      for (int m = 1; m <= 6; m++)
         for (int p = 0; p <= 3; p++) sweep_up(m, p);

      // R7 center mode sweep
      for (int m = 1; m <= 5; m++)
         for (int p = 0; p <= 2; p++) sweep_center(m, p);

      // R5 full range
      do_reset();
      modulo = 16'h0000;
      wr(8'h08);
      idle(65535);
      chk("R5 count at 65535 steps", 32'(count_out), 32'hFFFF);
      chk("R5 no flag before wrap", 32'(bus_rdata[7]), 32'h0);
      idle(1);
      chk("R5 wrap to zero", 32'(count_out), 32'h0);
      chk("R5 flag on wrap", 32'(bus_rdata[7]), 32'h1);

      // R3 R6 hold and prescaler restart
      do_reset();
      modulo = 16'd100;
      wr(8'h0A);
      idle(5);
      chk("R6 ps=2 after 5 pulses", 32'(count_out), 32'd1);
      wr(8'h02);
      idle(4);
      chk("R3 disabled hold", 32'(count_out), 32'd1);
      wr(8'h0A);
      idle(3);
      chk("R3 prescaler restarted (3 pulses)", 32'(count_out), 32'd1);
      idle(1);
      chk("R6 step at 4th pulse", 32'(count_out), 32'd2);

      // R8 R10 clear sequence
      do_reset();
      modulo = 16'd2;
      wr(8'h48);
      idle(3);
      chk("R8 flag set", 32'(bus_rdata[7]), 32'h1);
      chk("R10 irq with flag and enable", 32'(irq), 32'h1);
      wr(8'h40);
      chk("R8 write 0 without read", 32'(bus_rdata[7]), 32'h1);
      wr(8'hC0);
      chk("R8 write 1 no effect", 32'(bus_rdata[7]), 32'h1);
      rd();
      wr(8'h40);
      chk("R8 read then write 0 clears", 32'(bus_rdata[7]), 32'h0);
      chk("R10 irq low after clear", 32'(irq), 32'h0);

      // R9 overflow between read and write
      do_reset();
      modulo = 16'd3;
      wr(8'h08);
      idle(4);
      chk("R9 flag set", 32'(bus_rdata[7]), 32'h1);
      rd();
      idle(4);
      wr(8'h08);
      chk("R9 clear cancelled", 32'(bus_rdata[7]), 32'h1);
      chk("R10 irq low with enable 0", 32'(irq), 32'h0);
      wr(8'h00);
      rd();
      wr(8'h00);
      chk("R8 clear after fresh read", 32'(bus_rdata[7]), 32'h0);

      // R11 alternate and external sources
      do_reset();
      modulo = 16'd1000;
      wr(8'h10);
      pulse_alt(5);
      idle(4);
      chk("R11 alt edges counted", 32'(count_out), 32'd5);
      pulse_ext(2);
      idle(4);
      chk("R11 ext ignored while alt selected", 32'(count_out), 32'd5);
      wr(8'h18);
      pulse_alt(2);
      pulse_ext(3);
      idle(4);
      chk("R11 ext edges counted, alt ignored", 32'(count_out), 32'd8);

      // R12 value kept across mode changes
      do_reset();
      modulo = 16'd20;
      wr(8'h08);
      idle(7);
      chk("R12 up count", 32'(count_out), 32'd7);
      wr(8'h20);
      idle(3);
      chk("R12 kept entering center", 32'(count_out), 32'd8);
      wr(8'h28);
      idle(3);
      chk("R12 center continues from value", 32'(count_out), 32'd11);
      wr(8'h00);
      idle(2);
      chk("R12 kept leaving center", 32'(count_out), 32'd12);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule